// File: doc/BRIEF.md
# Period-Match Timer/Counter

This block is a 16-bit timer/counter peripheral driven from a small register bus. Its counter advances on prescaled ticks taken from one of three sources: every system clock cycle, rising edges on an external pin passed through a synchronizer, or rising edges on that pin caught by a single capture flop. When the counter holds the same value as the period register, the next tick returns it to zero and sets a sticky interrupt flag. Software clears the flag by writing the status register.

A gated mode measures how long the external pin stays high. The counter accumulates internal clock cycles while the synchronized pin level is high, and each falling edge of the pin sets the flag, marking the end of one measurement. A stop-in-idle option freezes counting while the idle input is asserted. Any write to the counter or the control register restarts the prescaler. A write to the control register never changes the counter.

Top module: `period_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the period reads 0xFFFF, control reads 0x0000, status reads 0 and `irq` is low.
- R2: Register addresses are 0 counter, 1 period, 2 control, 3 status. In control, bit 15 enables counting, bit 13 is stop-in-idle, bit 6 selects gated mode, bits 5:4 select the prescaler, bit 2 synchronizes the external pin and bit 1 selects the pin as source (0 = system clock). Every other control bit reads 0.
- R3: Each tick increments the counter. A tick that finds the counter equal to the period clears it to 0 and sets the flag.
- R4: Prescaler code 00 divides by 1, 01 by 8, 10 by 64 and 11 by 256, so K source events from a cleared prescaler give floor(K/N) ticks.
- R5: A write to the counter or to the control register clears the prescaler count.
- R6: A control write leaves the counter unchanged. With the enable bit at 0, the counter holds and no flag is set.
- R7: A counter write takes effect on its clock edge and wins over a period match in the same cycle. No flag is set from that match.
- R8: In synchronized external mode, a rising pin edge is counted on the third clock edge after the pin rises. Each pulse counts once.
- R9: In unsynchronized external mode, a rising pin edge is counted on the second clock edge after the pin rises.
- R10: In gated mode with the system clock selected, a pin held high across H clock edges adds exactly H to the counter. Each falling edge of the pin sets the flag.
- R11: Status bit 0 is the flag and bit 1 is the interrupt enable. Writing 1 to status bit 0 clears the flag, and a set event in the same cycle wins over the clear. `irq` is high exactly when the flag and the enable are both 1.
- R12: With stop-in-idle at 1, asserting `idle` freezes counting. With stop-in-idle at 0, counting continues during idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| ext_pin | input | 1 | External count edge or gate level |
| idle | input | 1 | Idle request from the system |
| irq | output | 1 | Interrupt request |

## Verification
Random period and prescaler settings are run for random lengths of time with the system clock as source. Comparing the counter and flag with the floor(K/N) modulo (P+1) formula separates divider, wrap and flag errors. Directed pulse trains on the pin are run once in each external mode. A read taken two edges after a rising edge distinguishes the synchronized path from the single-flop path. Gate pulses of known width check the accumulated count and the flag set on the falling edge. Rewrites of the counter and control part-way through a prescaler period, a counter write that lands on a match, and toggling idle with stop-in-idle at both values show whether the clear, priority and freeze rules are kept.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        A_COUNT  = 2'd0,
        A_PERIOD = 2'd1,
        A_CTRL   = 2'd2,
        A_STATUS = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       on;
        logic       stop_idle;
        logic       gate_en;
        logic [1:0] ps_sel;
        logic       ext_sync;
        logic       ext_src;
    } ctrl_t;

    localparam int unsigned CTRL_W = 16;

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
        return {c.on, 1'b0, c.stop_idle, 6'b0, c.gate_en, c.ps_sel,
                1'b0, c.ext_sync, c.ext_src, 1'b0};
    endfunction

    function automatic int unsigned ps_ratio(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 8;
            2'b10:   return 64;
            default: return 256;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_front.sv
module ptmr_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic ext_src,
    input  logic ext_sync,
    input  logic gate_en,
    output logic src_pulse,
    output logic gate_fall
);
    logic [SYNC_STAGES:0] chain_q;
    logic                 cap_q;
    logic                 cap_d_q;
    logic                 level;
    logic                 level_prev;
    logic                 use_gate;

    genvar gi;
    generate
        for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= 1'b0;
            cap_d_q <= 1'b0;
        end else begin
            cap_q   <= pin;
            cap_d_q <= cap_q;
        end
    end

    assign level      = chain_q[SYNC_STAGES-1];
    assign level_prev = chain_q[SYNC_STAGES];
    assign use_gate   = gate_en & ~ext_src;

    always_comb begin
        if (ext_src)       src_pulse = ext_sync ? (level & ~level_prev) : (cap_q & ~cap_d_q);
        else if (use_gate) src_pulse = level;
        else               src_pulse = 1'b1;
    end

    assign gate_fall = use_gate & level_prev & ~level;

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            src,
    input  logic            run,
    input  logic [1:0]      sel,
    output logic            tick,
    output logic [PS_W-1:0] ps_cnt
);
    import ptmr_pkg::*;

    logic [PS_W-1:0] last_val;
    logic            at_last;

    assign last_val = PS_W'(ps_ratio(sel) - 1);
    assign at_last  = (ps_cnt == last_val);
    assign tick     = src & run & at_last;

    always_ff @(posedge clk) begin
        if (rst || clr)     ps_cnt <= '0;
        else if (src && run) ps_cnt <= at_last ? '0 : ps_cnt + 1'b1;
    end

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wr_val,
    input  logic [DW-1:0] period,
    output logic [DW-1:0] count,
    output logic          match_evt
);
    logic at_period;

    assign at_period = (count == period);
    assign match_evt = tick & at_period & ~wr_cnt;

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (wr_cnt) count <= wr_val;
        else if (tick)   count <= at_period ? '0 : count + 1'b1;
    end

endmodule

// File: rtl/period_timer.sv
module period_timer #(
    parameter int DW          = 16,
    parameter int PS_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          ext_pin,
    input  logic          idle,
    output logic          irq
);
    import ptmr_pkg::*;

    localparam logic [DW-1:0] PERIOD_RST = '1;

    ctrl_t           ctrl_q;
    logic [DW-1:0]   period_q;
    logic [DW-1:0]   count_q;
    logic            flag_q;
    logic            ie_q;
    logic            wr_cnt, wr_per, wr_ctl, wr_irq;
    logic            run;
    logic            src_pulse, gate_fall, tick, match_evt, set_evt;
    logic [PS_W-1:0] ps_cnt;

    assign wr_cnt = wr_en && (wr_addr == A_COUNT);
    assign wr_per = wr_en && (wr_addr == A_PERIOD);
    assign wr_ctl = wr_en && (wr_addr == A_CTRL);
    assign wr_irq = wr_en && (wr_addr == A_STATUS);

    assign run = ctrl_q.on & ~(ctrl_q.stop_idle & idle);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= PERIOD_RST;
            ie_q     <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ctrl_q.on        <= wr_data[15];
                ctrl_q.stop_idle <= wr_data[13];
                ctrl_q.gate_en   <= wr_data[6];
                ctrl_q.ps_sel    <= wr_data[5:4];
                ctrl_q.ext_sync  <= wr_data[2];
                ctrl_q.ext_src   <= wr_data[1];
            end
            if (wr_per) period_q <= wr_data;
            if (wr_irq) ie_q     <= wr_data[1];
        end
    end

    ptmr_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .pin       (ext_pin),
        .ext_src   (ctrl_q.ext_src),
        .ext_sync  (ctrl_q.ext_sync),
        .gate_en   (ctrl_q.gate_en),
        .src_pulse (src_pulse),
        .gate_fall (gate_fall)
    );

    ptmr_prescale #(.PS_W(PS_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (wr_cnt | wr_ctl),
        .src    (src_pulse),
        .run    (run),
        .sel    (ctrl_q.ps_sel),
        .tick   (tick),
        .ps_cnt (ps_cnt)
    );

    ptmr_count #(.DW(DW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr_cnt    (wr_cnt),
        .wr_val    (wr_data),
        .period    (period_q),
        .count     (count_q),
        .match_evt (match_evt)
    );

    assign set_evt = match_evt | (gate_fall & run);

    always_ff @(posedge clk) begin
        if (rst)                      flag_q <= 1'b0;
        else if (set_evt)             flag_q <= 1'b1;
        else if (wr_irq && wr_data[0]) flag_q <= 1'b0;
    end

    assign irq = flag_q & ie_q;

    always_comb begin
        case (rd_addr)
            A_COUNT:  rd_data = count_q;
            A_PERIOD: rd_data = period_q;
            A_CTRL:   rd_data = DW'(pack_ctrl(ctrl_q));
            default:  rd_data = {{(DW-2){1'b0}}, ie_q, flag_q};
        endcase
    end

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int DW   = 16,
    parameter int PS_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            tick,
    input logic            run,
    input logic            wr_cnt,
    input logic            wr_irq,
    input logic [DW-1:0]   wr_data,
    input logic [DW-1:0]   count_q,
    input logic [DW-1:0]   period_q,
    input logic            flag_q,
    input logic [1:0]      ps_sel,
    input logic [PS_W-1:0] ps_cnt
);
    import ptmr_pkg::*;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_q == '0) && (period_q == '1) && !flag_q);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt && (count_q != period_q)) |=> count_q == DW'($past(count_q) + 1'b1));

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt && (count_q == period_q)) |=> (count_q == '0) && flag_q);

    // R7
    cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> count_q == $past(wr_data));

    // R6
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(count_q));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(wr_irq && wr_data[0])) |=> flag_q);

    // R4
    ps_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(ps_cnt) < int'(ps_ratio(ps_sel)));

endmodule

bind period_timer ptmr_chk #(.DW(DW), .PS_W(PS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run),
    .wr_cnt   (wr_cnt),
    .wr_irq   (wr_irq),
    .wr_data  (wr_data),
    .count_q  (count_q),
    .period_q (period_q),
    .flag_q   (flag_q),
    .ps_sel   (ctrl_q.ps_sel),
    .ps_cnt   (ps_cnt)
);

// File: tb/test_period_timer.sv
module test_period_timer;
    localparam logic [15:0] ON = 16'h8000, SIDL = 16'h2000, GATE = 16'h0040,
                            SYNC = 16'h0004, EXT = 16'h0002;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        ext_pin = 1'b0;
    logic        idle = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    period_timer i_period_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_pin(ext_pin), .idle(idle), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int div_of(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 8 : (sel == 2) ? 64 : 256;
    endfunction

    function automatic logic [15:0] exp_count(input int k, input int sel, input int p);
        return 16'((k / div_of(sel)) % (p + 1));
    endfunction

    function automatic logic [15:0] exp_flag(input int k, input int sel, input int p);
        return ((k / div_of(sel)) > p) ? 16'd1 : 16'd0;
    endfunction

    task automatic setup(input logic [15:0] period);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0000);
        wr(2'd1, period);
        wr(2'd3, 16'h0001);
    endtask

    task automatic pulse(input int hi, input int lo);
        ext_pin = 1'b1; wait_cyc(hi);
        ext_pin = 1'b0; wait_cyc(lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c0;
        void'($urandom(32'd1234));
        wait_cyc(4);
        rst = 1'b0;

        // R1 reset values
        rd(2'd0, v); chk("R1 counter", v, 16'h0000);
        rd(2'd1, v); chk("R1 period", v, 16'hFFFF);
        rd(2'd2, v); chk("R1 control", v, 16'h0000);
        rd(2'd3, v); chk("R1 status", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R2 control implemented bits
        wr(2'd2, 16'hFFFF);
        rd(2'd2, v); chk("R2 control mask", v, 16'hA076);

        // R3 match and wrap, /1 internal
        setup(16'd5);
        wr(2'd2, ON);
        wait_cyc(4);
        rd(2'd0, v); chk("R3 count before match", v, 16'd4);
        rd(2'd3, v); chk("R3 no flag before match", v, 16'd0);
        wait_cyc(2);
        rd(2'd0, v); chk("R3 wrap to zero", v, 16'd0);
        rd(2'd3, v); chk("R3 flag on wrap", v, 16'd1);

        // R11 sticky flag and irq gating
        wr(2'd2, 16'h0000);
        chk("R11 irq off without enable", {15'd0, irq}, 16'd0);
        wr(2'd3, 16'h0002);
        rd(2'd3, v); chk("R11 flag kept, enable set", v, 16'd3);
        chk("R11 irq on", {15'd0, irq}, 16'd1);
        wr(2'd3, 16'h0003);
        rd(2'd3, v); chk("R11 flag cleared", v, 16'd2);
        chk("R11 irq off after clear", {15'd0, irq}, 16'd0);
        wr(2'd3, 16'h0001);

        // R4 prescaler ratios
        setup(16'hFFFF); wr(2'd2, ON | 16'h0010); wait_cyc(50);
        rd(2'd0, v); chk("R4 div8", v, 16'd6);
        setup(16'hFFFF); wr(2'd2, ON | 16'h0020); wait_cyc(200);
        rd(2'd0, v); chk("R4 div64", v, 16'd3);
        setup(16'hFFFF); wr(2'd2, ON | 16'h0030); wait_cyc(600);
        rd(2'd0, v); chk("R4 div256", v, 16'd2);

        // R6 control write and disable hold the counter
        rd(2'd0, c0);
        wr(2'd2, 16'h0030);
        wait_cyc(30);
        rd(2'd0, v); chk("R6 hold when disabled", v, c0);
        wr(2'd2, 16'h0000);
        wait_cyc(5);
        rd(2'd0, v); chk("R6 control write keeps counter", v, c0);
        rd(2'd3, v); chk("R6 no flag when disabled", v, 16'd0);

        // R5 control rewrite clears prescaler
        setup(16'hFFFF);
        wr(2'd2, ON | 16'h0010);
        wait_cyc(4);
        wr(2'd2, ON | 16'h0010);
        wait_cyc(7);
        rd(2'd0, v); chk("R5 ctrl clear no tick yet", v, 16'd0);
        wait_cyc(1);
        rd(2'd0, v); chk("R5 ctrl clear tick on eighth", v, 16'd1);
        // R5 counter write clears prescaler
        wait_cyc(4);
        wr(2'd0, 16'd100);
        wait_cyc(7);
        rd(2'd0, v); chk("R5 counter clear no tick yet", v, 16'd100);
        wait_cyc(1);
        rd(2'd0, v); chk("R5 counter clear tick on eighth", v, 16'd101);

        // R7 counter write wins over match
        setup(16'd3);
        wr(2'd0, 16'd3);
        wr(2'd2, ON);
        wr(2'd0, 16'd1);
        rd(2'd0, v); chk("R7 written value wins", v, 16'd1);
        rd(2'd3, v); chk("R7 no flag from overridden match", v, 16'd0);
        wr(2'd2, 16'h0000);

        // R9 unsynchronized latency and count
        setup(16'hFFFF);
        wr(2'd2, ON | EXT);
        ext_pin = 1'b1; wait_cyc(2);
        rd(2'd0, v); chk("R9 counted on second edge", v, 16'd1);
        wait_cyc(2); ext_pin = 1'b0; wait_cyc(3);
        for (int i = 0; i < 4; i++) pulse(2, 3);
        wait_cyc(4);
        rd(2'd0, v); chk("R9 pulse count", v, 16'd5);

        // R8 synchronized latency and count
        setup(16'hFFFF);
        wr(2'd2, ON | EXT | SYNC);
        ext_pin = 1'b1; wait_cyc(2);
        rd(2'd0, v); chk("R8 not yet on second edge", v, 16'd0);
        wait_cyc(1);
        rd(2'd0, v); chk("R8 counted on third edge", v, 16'd1);
        wait_cyc(2); ext_pin = 1'b0; wait_cyc(3);
        for (int i = 0; i < 6; i++) pulse(3, 3);
        wait_cyc(4);
        rd(2'd0, v); chk("R8 pulse count", v, 16'd7);

        // R10 gated accumulation
        setup(16'hFFFF);
        wr(2'd2, ON | GATE);
        wait_cyc(10);
        rd(2'd0, v); chk("R10 no count with gate low", v, 16'd0);
        ext_pin = 1'b1; wait_cyc(17); ext_pin = 1'b0;
        wait_cyc(1);
        rd(2'd3, v); chk("R10 no flag before fall seen", v, 16'd0);
        wait_cyc(5);
        rd(2'd0, v); chk("R10 gate width", v, 16'd17);
        rd(2'd3, v); chk("R10 flag on falling gate", v, 16'd1);
        wr(2'd3, 16'h0001);
        pulse(9, 6);
        rd(2'd0, v); chk("R10 second accumulation", v, 16'd26);
        rd(2'd3, v); chk("R10 flag on second fall", v, 16'd1);

        // R12 idle behaviour
        setup(16'hFFFF);
        idle = 1'b1;
        wr(2'd2, ON | SIDL);
        wait_cyc(10);
        rd(2'd0, v); chk("R12 frozen in idle", v, 16'd0);
        idle = 1'b0; wait_cyc(10);
        rd(2'd0, v); chk("R12 counts out of idle", v, 16'd10);
        wr(2'd2, ON);
        idle = 1'b1; wait_cyc(9);
        rd(2'd0, v); chk("R12 counts in idle without stop", v, 16'd20);
        idle = 1'b0;

        // R3 R4 random periods and ratios
        for (int n = 0; n < 20; n++) begin
            int p, sel, k;
            p   = 1 + int'($urandom % 40);
            sel = int'($urandom % 3);
            k   = 50 + int'($urandom % 400);
            setup(16'(p));
            wr(2'd2, ON | 16'(sel << 4));
            wait_cyc(k);
            rd(2'd0, v); chk("R4 random count", v, exp_count(k, sel, p));
            rd(2'd3, v); chk("R3 random flag", v, exp_flag(k, sel, p));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule